// File: doc/BRIEF.md
# Ternary Longest-Prefix Lookup Table

This block is a small ternary match table for address lookup. Every entry stores a pattern value, a per-bit don't-care mask and a short output-port code. A host loads or replaces an entry by index through a write port, and may do so at any time, including while lookups are running. A lookup presents a key, which is compared against all live entries at once. One cycle later the block reports whether anything matched, which entry won and that entry's port code.

Don't-care bits must form a suffix: they sit at the least significant end, so each entry behaves as a prefix of some length. When several entries match one key, the entry with the most cared bits, which is the longest prefix, is chosen. Equal lengths fall back to the lower index. A write whose mask is not such a suffix is refused and reported on an error output.

Top module: `tcam_lpm_lookup`

## Requirements
- R1: A stored bit whose `wr_dc` bit is 1 matches either key value; a bit whose `wr_dc` bit is 0 matches only an equal key bit. An entry matches when all of its bits match. For example, pattern 101XX matches every key from 10100 to 10111.
- R2: A lookup requested with `srch_en` high at a rising edge shows its result on the outputs from that edge onward. `res_valid` is high for exactly one cycle per request and low when no request was made.
- R3: When several live entries match, the winner is the one with the most cared bits (zeros in its `wr_dc` mask). For example, key 01101 hits 0110X and 011XX, and 0110X wins.
- R4: Matching entries of equal prefix length resolve to the lower index.
- R5: On a hit, `res_hit` is 1, `res_idx` is the winning index and `res_port` is that entry's stored port code.
- R6: After reset every entry is invalid. A lookup that matches no live entry gives `res_hit`=0, `res_idx`=0 and `res_port`=0.
- R7: A write with `wr_live`=0 invalidates the entry at `wr_idx`, and the entry then never matches.
- R8: A lookup issued in the same cycle as a write sees the table as it was before that write. A lookup issued in the next cycle sees the new contents.
- R9: A write whose `wr_dc` mask is not of the form 0…01…1 (set bits contiguous from bit 0, the empty mask included) leaves the table unchanged and raises `wr_err` in the following cycle.
- R10: `wr_err` is 0 in any cycle that does not follow a refused write, including the cycle after an accepted write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Write one entry this cycle |
| wr_idx | input | IW | Entry index to write |
| wr_data | input | W | Pattern value |
| wr_dc | input | W | Don't-care mask, 1 = ignore bit |
| wr_port | input | PW | Output-port code stored with the entry |
| wr_live | input | 1 | 1 marks the entry valid, 0 removes it |
| wr_err | output | 1 | Previous cycle's write was refused |
| srch_en | input | 1 | Lookup request |
| srch_key | input | W | Lookup key |
| res_valid | output | 1 | Result of a request is present |
| res_hit | output | 1 | Some live entry matched |
| res_idx | output | IW | Winning entry index |
| res_port | output | PW | Winning entry's port code |

## Verification
Both the lookup result and `wr_err` are registered once. Each therefore appears on the rising edge that samples the request or write, and stays until the following edge. The bench drives every input on a falling edge and reads the outputs one nanosecond after the next rising edge. It then clears the request and confirms at the edge after that that `res_valid` and `wr_err` have dropped. The same-cycle case drives a write and a lookup on one falling edge and expects the old port code from the first edge. A second lookup then expects the new code.

// File: rtl/tcam_lpm_pkg.sv
package tcam_lpm_pkg;

    localparam int unsigned MAX_W = 64;

    // A don't-care mask is legal only when its set bits run unbroken from bit 0.
    function automatic logic suffix_mask_ok(input logic [MAX_W-1:0] m);
        return (m & (m + 1'b1)) == '0;
    endfunction

endpackage

// File: rtl/tcam_entry_store.sv
module tcam_entry_store #(
    parameter int unsigned N  = 8,
    parameter int unsigned W  = 5,
    parameter int unsigned PW = 3,
    localparam int unsigned IW = (N > 1) ? $clog2(N) : 1
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  wr_en,
    input  logic [IW-1:0]         wr_idx,
    input  logic [W-1:0]          wr_data,
    input  logic [W-1:0]          wr_dc,
    input  logic [PW-1:0]         wr_port,
    input  logic                  wr_live,
    output logic                  wr_err,
    output logic [N-1:0]          ent_valid,
    output logic [N-1:0][W-1:0]   ent_data,
    output logic [N-1:0][W-1:0]   ent_dc,
    output logic [N-1:0][PW-1:0]  ent_port
);
    import tcam_lpm_pkg::*;

    logic mask_ok;
    logic idx_ok;
    logic accept;

    assign mask_ok = suffix_mask_ok(tcam_lpm_pkg::MAX_W'(wr_dc));
    assign idx_ok  = (32'(wr_idx) < N);
    assign accept  = wr_en && mask_ok && idx_ok;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ent_valid <= '0;
            wr_err    <= 1'b0;
        end else begin
            wr_err <= wr_en && !(mask_ok && idx_ok);
            if (accept) begin
                ent_valid[wr_idx] <= wr_live;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (accept) begin
            ent_data[wr_idx] <= wr_data;
            ent_dc[wr_idx]   <= wr_dc;
            ent_port[wr_idx] <= wr_port;
        end
    end

endmodule

// File: rtl/tcam_match_plane.sv
module tcam_match_plane #(
    parameter int unsigned N  = 8,
    parameter int unsigned W  = 5,
    localparam int unsigned LW = $clog2(W + 1)
) (
    input  logic [W-1:0]          key,
    input  logic [N-1:0]          ent_valid,
    input  logic [N-1:0][W-1:0]   ent_data,
    input  logic [N-1:0][W-1:0]   ent_dc,
    output logic [N-1:0]          row_hit,
    output logic [N-1:0][LW-1:0]  row_len
);

    for (genvar r = 0; r < N; r++) begin : g_row
        logic [W-1:0] diff;
        assign diff       = (key ^ ent_data[r]) & ~ent_dc[r];
        assign row_hit[r] = ent_valid[r] && (diff == '0);
        assign row_len[r] = LW'(W - $countones(ent_dc[r]));
    end

endmodule

// File: rtl/tcam_prefix_select.sv
module tcam_prefix_select #(
    parameter int unsigned N  = 8,
    parameter int unsigned W  = 5,
    localparam int unsigned LW = $clog2(W + 1),
    localparam int unsigned IW = (N > 1) ? $clog2(N) : 1
) (
    input  logic [N-1:0]          row_hit,
    input  logic [N-1:0][LW-1:0]  row_len,
    output logic                  any_hit,
    output logic [IW-1:0]         win_idx
);
    logic [LW-1:0] best_len;

    // Strictly-greater test keeps the earlier (lower) index on equal lengths.
    always_comb begin
        any_hit  = 1'b0;
        win_idx  = '0;
        best_len = '0;
        for (int i = 0; i < N; i++) begin
            if (row_hit[i] && (!any_hit || row_len[i] > best_len)) begin
                any_hit  = 1'b1;
                win_idx  = IW'(i);
                best_len = row_len[i];
            end
        end
    end

endmodule

// File: rtl/tcam_lpm_lookup.sv
module tcam_lpm_lookup #(
    parameter int unsigned N  = 8,
    parameter int unsigned W  = 5,
    parameter int unsigned PW = 3,
    localparam int unsigned IW = (N > 1) ? $clog2(N) : 1,
    localparam int unsigned LW = $clog2(W + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [IW-1:0] wr_idx,
    input  logic [W-1:0]  wr_data,
    input  logic [W-1:0]  wr_dc,
    input  logic [PW-1:0] wr_port,
    input  logic          wr_live,
    output logic          wr_err,
    input  logic          srch_en,
    input  logic [W-1:0]  srch_key,
    output logic          res_valid,
    output logic          res_hit,
    output logic [IW-1:0] res_idx,
    output logic [PW-1:0] res_port
);

    logic [N-1:0]          ent_valid;
    logic [N-1:0][W-1:0]   ent_data;
    logic [N-1:0][W-1:0]   ent_dc;
    logic [N-1:0][PW-1:0]  ent_port;
    logic [N-1:0]          row_hit;
    logic [N-1:0][LW-1:0]  row_len;
    logic                  any_hit;
    logic [IW-1:0]         win_idx;

    tcam_entry_store #(.N(N), .W(W), .PW(PW)) store_i (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (wr_en),
        .wr_idx    (wr_idx),
        .wr_data   (wr_data),
        .wr_dc     (wr_dc),
        .wr_port   (wr_port),
        .wr_live   (wr_live),
        .wr_err    (wr_err),
        .ent_valid (ent_valid),
        .ent_data  (ent_data),
        .ent_dc    (ent_dc),
        .ent_port  (ent_port)
    );

    tcam_match_plane #(.N(N), .W(W)) plane_i (
        .key       (srch_key),
        .ent_valid (ent_valid),
        .ent_data  (ent_data),
        .ent_dc    (ent_dc),
        .row_hit   (row_hit),
        .row_len   (row_len)
    );

    tcam_prefix_select #(.N(N), .W(W)) sel_i (
        .row_hit (row_hit),
        .row_len (row_len),
        .any_hit (any_hit),
        .win_idx (win_idx)
    );

    // Result register: compares use the table as it stood before this edge.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            res_valid <= 1'b0;
            res_hit   <= 1'b0;
            res_idx   <= '0;
            res_port  <= '0;
        end else begin
            res_valid <= srch_en;
            if (srch_en && any_hit) begin
                res_hit  <= 1'b1;
                res_idx  <= win_idx;
                res_port <= ent_port[win_idx];
            end else begin
                res_hit  <= 1'b0;
                res_idx  <= '0;
                res_port <= '0;
            end
        end
    end

endmodule

// File: rtl/tcam_lpm_checker.sv
module tcam_lpm_checker #(
    parameter int unsigned N  = 8,
    parameter int unsigned W  = 5,
    parameter int unsigned IW = 3,
    parameter int unsigned PW = 3
) (
    input logic          clk,
    input logic          rst_n,
    input logic          wr_en,
    input logic [W-1:0]  wr_dc,
    input logic          wr_err,
    input logic          srch_en,
    input logic          res_valid,
    input logic          res_hit,
    input logic [IW-1:0] res_idx,
    input logic [PW-1:0] res_port
);

    assert_result_follows_request_R2: assert property (
        @(posedge clk) disable iff (!rst_n) srch_en |=> res_valid);

    assert_no_result_without_request_R2: assert property (
        @(posedge clk) disable iff (!rst_n) !srch_en |=> !res_valid);

    assert_miss_outputs_zero_R6: assert property (
        @(posedge clk) disable iff (!rst_n)
        !res_hit |-> (res_port == '0 && res_idx == '0));

    assert_hit_needs_request_R2: assert property (
        @(posedge clk) disable iff (!rst_n) res_hit |-> res_valid);

    assert_bad_mask_flagged_R9: assert property (
        @(posedge clk) disable iff (!rst_n)
        (wr_en && ((wr_dc & (wr_dc + 1'b1)) != '0)) |=> wr_err);

    assert_err_only_after_write_R10: assert property (
        @(posedge clk) disable iff (!rst_n) !wr_en |=> !wr_err);

    assert_hit_index_in_range_R5: assert property (
        @(posedge clk) disable iff (!rst_n) res_hit |-> (32'(res_idx) < N));

endmodule

bind tcam_lpm_lookup tcam_lpm_checker #(.N(N), .W(W), .IW(IW), .PW(PW)) chk_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (wr_en),
    .wr_dc     (wr_dc),
    .wr_err    (wr_err),
    .srch_en   (srch_en),
    .res_valid (res_valid),
    .res_hit   (res_hit),
    .res_idx   (res_idx),
    .res_port  (res_port)
);

// File: tb/tcam_lpm_lookup_tb_top.sv
`timescale 1ns/1ps
module tcam_lpm_lookup_tb_top;

    localparam int N  = 8;
    localparam int W  = 5;
    localparam int PW = 3;
    localparam int IW = 3;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          wr_en = 1'b0;
    logic [IW-1:0] wr_idx = '0;
    logic [W-1:0]  wr_data = '0;
    logic [W-1:0]  wr_dc = '0;
    logic [PW-1:0] wr_port = '0;
    logic          wr_live = 1'b0;
    logic          wr_err;
    logic          srch_en = 1'b0;
    logic [W-1:0]  srch_key = '0;
    logic          res_valid;
    logic          res_hit;
    logic [IW-1:0] res_idx;
    logic [PW-1:0] res_port;

    int n_checks = 0;
    int n_fail   = 0;

    always #2 clk = ~clk;

    tcam_lpm_lookup #(.N(N), .W(W), .PW(PW)) dut_i (
        .clk(clk), .rst_n(rst_n),
        .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data), .wr_dc(wr_dc),
        .wr_port(wr_port), .wr_live(wr_live), .wr_err(wr_err),
        .srch_en(srch_en), .srch_key(srch_key),
        .res_valid(res_valid), .res_hit(res_hit), .res_idx(res_idx), .res_port(res_port)
    );

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic quiet();
        @(negedge clk);
        wr_en   = 1'b0;
        srch_en = 1'b0;
    endtask

    task automatic put(input int idx, input int data, input int dc, input int port,
                       input bit live, input bit exp_err, input string tag);
        @(negedge clk);
        wr_en = 1'b1; wr_idx = IW'(idx); wr_data = W'(data); wr_dc = W'(dc);
        wr_port = PW'(port); wr_live = live;
        @(posedge clk); #1;
        check(wr_err == exp_err, tag, int'(wr_err), int'(exp_err));
        quiet();
    endtask

    task automatic look(input int key, input bit exp_hit, input int exp_idx,
                        input int exp_port, input string tag);
        @(negedge clk);
        srch_en = 1'b1; srch_key = W'(key);
        @(posedge clk); #1;
        check(res_valid == 1'b1, {tag, " valid"}, int'(res_valid), 1);
        check(res_hit == exp_hit, {tag, " hit"}, int'(res_hit), int'(exp_hit));
        check(int'(res_idx) == exp_idx, {tag, " idx"}, int'(res_idx), exp_idx);
        check(int'(res_port) == exp_port, {tag, " port"}, int'(res_port), exp_port);
        quiet();
    endtask

    task automatic test_reset_state();
        check(res_valid == 1'b0, "R2 reset valid", int'(res_valid), 0);
        check(wr_err == 1'b0, "R10 reset err", int'(wr_err), 0);
        look(5'b10100, 1'b0, 0, 0, "R6 empty table");
        @(posedge clk); #1;
        check(res_valid == 1'b0, "R2 valid drops", int'(res_valid), 0);
    endtask

    task automatic test_load_and_match();
        put(0, 5'b10100, 5'b00011, 1, 1'b1, 1'b0, "R10 load 0");
        put(1, 5'b01100, 5'b00001, 2, 1'b1, 1'b0, "R10 load 1");
        put(2, 5'b01100, 5'b00011, 3, 1'b1, 1'b0, "R10 load 2");
        put(3, 5'b10011, 5'b00000, 4, 1'b1, 1'b0, "R10 load 3");
        for (int k = 5'b10100; k <= 5'b10111; k++)
            look(k, 1'b1, 0, 1, "R1 range 101XX");
        look(5'b10011, 1'b1, 3, 4, "R5 exact entry");
        look(5'b00000, 1'b0, 0, 0, "R6 miss");
    endtask

    task automatic test_longest_prefix();
        look(5'b01101, 1'b1, 1, 2, "R3 longer wins");
        look(5'b01110, 1'b1, 2, 3, "R3 only shorter");
    endtask

    task automatic test_tie_and_remove();
        put(5, 5'b01100, 5'b00011, 6, 1'b1, 1'b0, "R10 load 5");
        look(5'b01110, 1'b1, 2, 3, "R4 tie lower index");
        put(2, 5'b01100, 5'b00011, 3, 1'b0, 1'b0, "R10 remove 2");
        look(5'b01110, 1'b1, 5, 6, "R7 removed entry skipped");
    endtask

    task automatic test_bad_mask();
        put(0, 5'b00000, 5'b00101, 7, 1'b1, 1'b1, "R9 bad mask err");
        @(posedge clk); #1;
        check(wr_err == 1'b0, "R10 err one cycle", int'(wr_err), 0);
        look(5'b10101, 1'b1, 0, 1, "R9 entry unchanged");
        put(6, 5'b11111, 5'b11111, 7, 1'b1, 1'b0, "R10 all-dc accepted");
        look(5'b00000, 1'b1, 6, 7, "R1 full wildcard");
    endtask

    task automatic test_same_cycle();
        @(negedge clk);
        wr_en = 1'b1; wr_idx = 3'd3; wr_data = 5'b10011; wr_dc = '0;
        wr_port = 3'd5; wr_live = 1'b1;
        srch_en = 1'b1; srch_key = 5'b10011;
        @(posedge clk); #1;
        check(int'(res_port) == 4, "R8 old contents", int'(res_port), 4);
        quiet();
        look(5'b10011, 1'b1, 3, 5, "R8 new contents");
    endtask

    initial begin
        #(200000 * 4);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog actual=0 expected=1");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(posedge clk); #1;
        test_reset_state();
        test_load_and_match();
        test_longest_prefix();
        test_tie_and_remove();
        test_bad_mask();
        test_same_cycle();
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

endmodule